// File: doc/BRIEF.md
# Flash Command Unlock Sequence Decoder

This block is the command interpreter of a byte-wide NOR flash die. Every bus write reaches it as a one-cycle strobe that carries a 19-bit address and a data byte. The block tracks these writes through the fixed two-write unlock prefix and the command byte that follows. When a sequence completes it emits a one-cycle command pulse with a 3-bit code. For a byte program it also latches the target address and data. For a sector erase it latches the sector address. The flash array, the program and erase pulse timing and the multi-sector erase window sit outside this block. The array controller reports the end of an operation on `op_done`.

The unlock and command addresses are compared on address bits 14:0 only. Bits 18:15 matter only for the program address and the erase sector. A write that breaks a sequence drops the machine back to read mode without any command. A single write of F0h at any address resets the machine from every state except program-data entry, busy and suspend. The program's address and data are both taken from the same strobe, because a synchronous strobe has no separate falling and rising write edges.

States:
- `S_READ`: read mode.
- `S_UNLK1` and `S_UNLK2`: the first and second unlock writes have been seen.
- `S_AUTO`: autoselect mode.
- `S_PROG`: waiting for the program address and data.
- `S_ESET`, `S_EUNLK1` and `S_EUNLK2`: erase setup, followed by its two unlock writes.
- `S_BUSY`: a program or chip erase is running.
- `S_BUSY_SE`: a sector erase is running.
- `S_SUSP`: the sector erase is suspended.

Transitions:
- From `S_READ` or `S_AUTO`, AA@5555 goes to `S_UNLK1`.
- From `S_UNLK1`, 55@2AAA goes to `S_UNLK2`.
- From `S_UNLK2`, a write at 5555 goes to:
  - `S_AUTO` for 90h;
  - `S_PROG` for A0h;
  - `S_ESET` for 80h.
- From `S_PROG`, any write goes to `S_BUSY`.
- From `S_ESET`, AA@5555 goes to `S_EUNLK1`.
- From `S_EUNLK1`, 55@2AAA goes to `S_EUNLK2`.
- From `S_EUNLK2`:
  - 10h@5555 goes to `S_BUSY`;
  - 30h at any address goes to `S_BUSY_SE`.
- From `S_BUSY_SE`, B0h goes to `S_SUSP`.
- From `S_SUSP`, 30h goes to `S_BUSY_SE`.
- From either busy state, `op_done` goes to `S_READ`.
- Any F0h write, or any mismatching write in an unlock or setup state, goes to `S_READ`.

Top module: `fcmd_decoder`

## Requirements
- R1: While reset is held, and after it is released, `mode` is 00 (read) and `cmd_pulse` is 0.
- R2: The unlock prefix is AAh at address 5555h followed by 55h at 2AAAh. Address bits 18:15 are ignored in this match and in the 5555h command address.
- R3: A write of F0h at any address in read, autoselect, unlock or setup states produces `cmd_code` 1 (reset) and leaves `mode` 00.
- R4: The prefix followed by 90h at 5555h produces code 2 (autoselect). `mode` then reads 01 until a reset.
- R5: The prefix followed by A0h at 5555h, then any write, produces code 3 (program). That last write's address is latched on `cmd_addr` and its data on `cmd_data`, and `mode` becomes 10 (busy).
- R6: The prefix, 80h@5555h, AAh@5555h, 55h@2AAAh, then 10h@5555h produces code 4 (chip erase) with `mode` 10.
- R7: The same erase prefix followed by 30h at any address produces code 5 (sector erase). The full address is latched on `cmd_addr`, and its bits 18:16 name the sector.
- R8: A write that does not match the expected step returns the machine to read mode without a command, so a later correct step completes nothing. A third command byte other than F0h, 90h, A0h or 80h is one such mismatch.
- R9: While `mode` is 10, writes produce no command and `mode` stays 10 until `op_done` returns it to 00.
- R10: During a sector erase, B0h at any address produces code 6 (suspend) with `mode` 00. During a program or chip erase, B0h is ignored. While suspended, writes other than 30h are ignored.
- R11: While suspended, 30h at any address produces code 7 (resume) and `mode` returns to 10.
- R12: `cmd_pulse` lasts one cycle and rises in the cycle after the write strobe that completes the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data byte |
| op_done | input | 1 | The array reports that the program or erase has finished |
| mode | output | 2 | 00 read, 01 autoselect, 10 busy |
| cmd_pulse | output | 1 | One-cycle decoded-command strobe |
| cmd_code | output | 3 | Decoded command, 0 when idle |
| cmd_addr | output | 19 | Latched program or sector address |
| cmd_data | output | 8 | Latched program data |

## Verification
On every cycle, the assertions check the local, state-to-output relations:
- every pulse follows a write strobe;
- program and sector commands carry the address and data of the write that completed them;
- suspend, resume, reset and autoselect leave the matching mode;
- busy stays quiet until `op_done` or a suspend.

Only the bench's sweeps can show the global behaviours:
- the whole unlock prefix must be seen in order;
- every one of the 256 possible third bytes is decoded correctly;
- upper address bits are ignored across all 16 patterns;
- each of the 8 sectors goes through erase, suspend and resume.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        MODE_READ = 2'b00,
        MODE_AUTO = 2'b01,
        MODE_BUSY = 2'b10
    } mode_e;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_RESET  = 3'd1,
        CMD_AUTO   = 3'd2,
        CMD_PROG   = 3'd3,
        CMD_CHIP   = 3'd4,
        CMD_SECT   = 3'd5,
        CMD_SUSP   = 3'd6,
        CMD_RESUME = 3'd7
    } cmd_e;

    // class of a write's data byte
    typedef enum logic [2:0] {
        DC_OTHER,
        DC_RESET,
        DC_AUTO,
        DC_PSETUP,
        DC_ESETUP,
        DC_CHIP,
        DC_SECT,
        DC_SUSP
    } dclass_e;

endpackage

// File: rtl/fcmd_match.sv
module fcmd_match
    import fcmd_pkg::*;
#(
    parameter int MATCH_W = 15,
    parameter int DATA_W  = 8,
    parameter logic [MATCH_W-1:0] UNLK_ADDR_A = 15'h5555,
    parameter logic [MATCH_W-1:0] UNLK_ADDR_B = 15'h2AAA
) (
    input  logic [MATCH_W-1:0] addr_lo,
    input  logic [DATA_W-1:0]  data,
    output logic               at_a,
    output logic               at_b,
    output logic               key1,
    output logic               key2,
    output dclass_e            dclass
);
    localparam logic [DATA_W-1:0] K_KEY1   = DATA_W'(8'hAA);
    localparam logic [DATA_W-1:0] K_KEY2   = DATA_W'(8'h55);
    localparam logic [DATA_W-1:0] K_RESET  = DATA_W'(8'hF0);
    localparam logic [DATA_W-1:0] K_AUTO   = DATA_W'(8'h90);
    localparam logic [DATA_W-1:0] K_PSETUP = DATA_W'(8'hA0);
    localparam logic [DATA_W-1:0] K_ESETUP = DATA_W'(8'h80);
    localparam logic [DATA_W-1:0] K_CHIP   = DATA_W'(8'h10);
    localparam logic [DATA_W-1:0] K_SECT   = DATA_W'(8'h30);
    localparam logic [DATA_W-1:0] K_SUSP   = DATA_W'(8'hB0);

    assign at_a = (addr_lo == UNLK_ADDR_A);
    assign at_b = (addr_lo == UNLK_ADDR_B);
    assign key1 = (data == K_KEY1);
    assign key2 = (data == K_KEY2);

    always_comb begin
        unique case (data)
            K_RESET:  dclass = DC_RESET;
            K_AUTO:   dclass = DC_AUTO;
            K_PSETUP: dclass = DC_PSETUP;
            K_ESETUP: dclass = DC_ESETUP;
            K_CHIP:   dclass = DC_CHIP;
            K_SECT:   dclass = DC_SECT;
            K_SUSP:   dclass = DC_SUSP;
            default:  dclass = DC_OTHER;
        endcase
    end
endmodule

// File: rtl/fcmd_fsm.sv
module fcmd_fsm
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    input  logic              at_a,
    input  logic              at_b,
    input  logic              key1,
    input  logic              key2,
    input  dclass_e           dclass,
    output logic [1:0]        mode,
    output logic              cmd_pulse,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    typedef enum logic [3:0] {
        S_READ, S_UNLK1, S_UNLK2, S_AUTO, S_PROG,
        S_ESET, S_EUNLK1, S_EUNLK2, S_BUSY, S_BUSY_SE, S_SUSP
    } state_e;

    state_e state, nxt;
    cmd_e   emit;
    mode_e  mode_w;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_READ;
        else        state <= nxt;
    end

    // next state and command decision
    always_comb begin
        nxt  = state;
        emit = CMD_NONE;
        if (op_done && (state == S_BUSY || state == S_BUSY_SE)) begin
            nxt = S_READ;
        end else if (wr_valid) begin
            unique case (state)
                S_READ, S_AUTO: begin
                    if (dclass == DC_RESET) begin
                        emit = CMD_RESET;
                        nxt  = S_READ;
                    end else if (key1 && at_a) begin
                        nxt = S_UNLK1;
                    end
                end
                S_UNLK1, S_ESET, S_EUNLK1: begin
                    if (dclass == DC_RESET) begin
                        emit = CMD_RESET;
                        nxt  = S_READ;
                    end else if (state == S_UNLK1 && key2 && at_b) begin
                        nxt = S_UNLK2;
                    end else if (state == S_ESET && key1 && at_a) begin
                        nxt = S_EUNLK1;
                    end else if (state == S_EUNLK1 && key2 && at_b) begin
                        nxt = S_EUNLK2;
                    end else begin
                        nxt = S_READ;
                    end
                end
                S_UNLK2: begin
                    nxt = S_READ;
                    if (dclass == DC_RESET) begin
                        emit = CMD_RESET;
                    end else if (at_a && dclass == DC_AUTO) begin
                        emit = CMD_AUTO;
                        nxt  = S_AUTO;
                    end else if (at_a && dclass == DC_PSETUP) begin
                        nxt = S_PROG;
                    end else if (at_a && dclass == DC_ESETUP) begin
                        nxt = S_ESET;
                    end
                end
                S_PROG: begin
                    emit = CMD_PROG;
                    nxt  = S_BUSY;
                end
                S_EUNLK2: begin
                    nxt = S_READ;
                    if (dclass == DC_RESET) begin
                        emit = CMD_RESET;
                    end else if (at_a && dclass == DC_CHIP) begin
                        emit = CMD_CHIP;
                        nxt  = S_BUSY;
                    end else if (dclass == DC_SECT) begin
                        emit = CMD_SECT;
                        nxt  = S_BUSY_SE;
                    end
                end
                S_BUSY: ;
                S_BUSY_SE: begin
                    if (dclass == DC_SUSP) begin
                        emit = CMD_SUSP;
                        nxt  = S_SUSP;
                    end
                end
                S_SUSP: begin
                    if (dclass == DC_SECT) begin
                        emit = CMD_RESUME;
                        nxt  = S_BUSY_SE;
                    end
                end
                default: nxt = S_READ;
            endcase
        end
    end

    // registered command outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_pulse <= 1'b0;
            cmd_code  <= CMD_NONE;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_pulse <= (emit != CMD_NONE);
            cmd_code  <= emit;
            if (emit == CMD_PROG) begin
                cmd_addr <= wr_addr;
                cmd_data <= wr_data;
            end else if (emit == CMD_SECT) begin
                cmd_addr <= wr_addr;
            end
        end
    end

    always_comb begin
        unique case (state)
            S_AUTO:            mode_w = MODE_AUTO;
            S_BUSY, S_BUSY_SE: mode_w = MODE_BUSY;
            default:           mode_w = MODE_READ;
        endcase
    end
    assign mode = mode_w;
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int MATCH_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    output logic [1:0]        mode,
    output logic              cmd_pulse,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    logic    at_a, at_b, key1, key2;
    dclass_e dclass;

    fcmd_match #(.MATCH_W(MATCH_W), .DATA_W(DATA_W)) u_match (
        .addr_lo (wr_addr[MATCH_W-1:0]),
        .data    (wr_data),
        .at_a    (at_a),
        .at_b    (at_b),
        .key1    (key1),
        .key2    (key2),
        .dclass  (dclass)
    );

    fcmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .op_done   (op_done),
        .at_a      (at_a),
        .at_b      (at_b),
        .key1      (key1),
        .key2      (key2),
        .dclass    (dclass),
        .mode      (mode),
        .cmd_pulse (cmd_pulse),
        .cmd_code  (cmd_code),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              op_done,
    input logic [1:0]        mode,
    input logic              cmd_pulse,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data
);
    p_pulse_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse |-> $past(wr_valid));

    p_reset_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && cmd_code == 3'd1) |-> mode == 2'b00);

    p_auto_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && cmd_code == 3'd2) |-> mode == 2'b01);

    p_prog_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && cmd_code == 3'd3) |->
            (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data) && mode == 2'b10));

    p_chip_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && cmd_code == 3'd4) |-> mode == 2'b10);

    p_sect_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && cmd_code == 3'd5) |-> (cmd_addr == $past(wr_addr) && mode == 2'b10));

    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b10 && !$past(op_done) &&
         !($past(wr_valid) && $past(wr_data) == 8'hB0)) |-> (mode == 2'b10 && !cmd_pulse));

    p_suspend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && cmd_code == 3'd6) |-> ($past(mode) == 2'b10 && mode == 2'b00));

    p_resume_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse && cmd_code == 3'd7) |-> ($past(mode) == 2'b00 && mode == 2'b10));

    p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);
endmodule

bind fcmd_decoder fcmd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .op_done   (op_done),
    .mode      (mode),
    .cmd_pulse (cmd_pulse),
    .cmd_code  (cmd_code),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
);

// File: tb/tb_fcmd_decoder.sv
module tb_fcmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        op_done = 1'b0;
    logic [1:0]  mode;
    logic        cmd_pulse;
    logic [2:0]  cmd_code;
    logic [18:0] cmd_addr;
    logic [7:0]  cmd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic       got_pulse;
    logic [2:0] got_code;

    always #5 clk = ~clk;

    fcmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .op_done(op_done), .mode(mode), .cmd_pulse(cmd_pulse),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid  = 1'b0;
        got_pulse = cmd_pulse;
        got_code  = cmd_code;
    endtask

    // pulse+code as one number: 0 when no command
    task automatic exp_cmd(input string req, input int code);
        int act;
        int exp;
        act = got_pulse ? (8 + int'(got_code)) : int'(got_code);
        exp = (code != 0) ? (8 + code) : 0;
        chk(act == exp, req, "command", act, exp);
    endtask

    task automatic exp_mode(input string req, input int m);
        chk(int'(mode) == m, req, "mode", int'(mode), m);
    endtask

    task automatic unlock(input logic [3:0] hi);
        wr({hi, 15'h5555}, 8'hAA);
        wr({hi ^ 4'h5, 15'h2AAA}, 8'h55);
    endtask

    task automatic finish_op;
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        exp_mode("R1", 0);
        chk(cmd_pulse == 1'b0, "R1", "pulse in reset", int'(cmd_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        exp_mode("R1", 0);
        chk(cmd_pulse == 1'b0, "R1", "pulse after reset", int'(cmd_pulse), 0);

        // R2 R4 R12 R3: autoselect with every upper-bit pattern
        for (int h = 0; h < 16; h++) begin
            unlock(4'(h));
            wr({4'(h) ^ 4'hA, 15'h5555}, 8'h90);
            exp_cmd("R2", 2);
            exp_mode("R4", 1);
            @(negedge clk);
            chk(cmd_pulse == 1'b0, "R12", "pulse width", int'(cmd_pulse), 0);
            exp_mode("R4", 1);
            wr(19'(h * 4099), 8'hF0);
            exp_cmd("R3", 1);
            exp_mode("R3", 0);
        end

        // R8 R3 R4 R5: sweep every third command byte
        for (int d = 0; d < 256; d++) begin
            unlock(4'(d));
            wr({4'(d >> 4), 15'h5555}, 8'(d));
            if (d == 'hF0) begin
                exp_cmd("R3", 1); exp_mode("R3", 0);
            end else if (d == 'h90) begin
                exp_cmd("R4", 2); exp_mode("R4", 1);
                wr(19'h0, 8'hF0);
                exp_cmd("R3", 1);
            end else if (d == 'hA0) begin
                exp_cmd("R5", 0);
                wr(19'h6ABCD, 8'h3C);
                exp_cmd("R5", 3);
                chk(cmd_addr == 19'h6ABCD, "R5", "addr", int'(cmd_addr), 'h6ABCD);
                chk(cmd_data == 8'h3C, "R5", "data", int'(cmd_data), 'h3C);
                exp_mode("R5", 2);
                finish_op;
                exp_mode("R9", 0);
            end else if (d == 'h80) begin
                exp_cmd("R8", 0);
                wr(19'h1, 8'hF0);
                exp_cmd("R3", 1);
            end else begin
                exp_cmd("R8", 0);
                exp_mode("R8", 0);
            end
        end

        // R8: broken prefixes complete nothing
        wr(19'h5555, 8'hAA);
        wr(19'h2AAB, 8'h55);
        exp_cmd("R8", 0);
        wr(19'h5555, 8'h90);
        exp_cmd("R8", 0);
        exp_mode("R8", 0);
        wr(19'h5554, 8'hAA);
        wr(19'h2AAA, 8'h55);
        wr(19'h5555, 8'h90);
        exp_cmd("R8", 0);
        exp_mode("R8", 0);

        // R3: F0 mid-sequence and back-to-back
        wr(19'h5555, 8'hAA);
        wr(19'h7123, 8'hF0);
        exp_cmd("R3", 1);
        wr(19'h0, 8'hF0);
        exp_cmd("R3", 1);
        wr(19'h2AAA, 8'h55);
        exp_cmd("R8", 0);

        // R5 R9 R10: program, busy ignores writes
        for (int i = 0; i < 8; i++) begin
            unlock(4'(i));
            wr(19'h5555, 8'hA0);
            wr(19'(i * 65537 + 3), (i == 2) ? 8'hF0 : 8'(i * 17));
            exp_cmd("R5", 3);
            chk(cmd_addr == 19'(i * 65537 + 3), "R5", "addr", int'(cmd_addr), (i * 65537 + 3) & 'h7FFFF);
            chk(cmd_data == ((i == 2) ? 8'hF0 : 8'(i * 17)), "R5", "data", int'(cmd_data),
                (i == 2) ? 'hF0 : ((i * 17) & 'hFF));
            wr(19'h5555, 8'hAA);
            exp_cmd("R9", 0); exp_mode("R9", 2);
            wr(19'h0, 8'hF0);
            exp_cmd("R9", 0); exp_mode("R9", 2);
            wr(19'h0, 8'hB0);
            exp_cmd("R10", 0); exp_mode("R10", 2);
            finish_op;
            exp_mode("R9", 0);
        end

        // R6 chip erase, B0 ignored
        unlock(4'h3);
        wr(19'h5555, 8'h80);
        unlock(4'hC);
        wr(19'h5555, 8'h10);
        exp_cmd("R6", 4);
        exp_mode("R6", 2);
        wr(19'h44, 8'hB0);
        exp_cmd("R10", 0); exp_mode("R10", 2);
        finish_op;
        exp_mode("R9", 0);

        // R8: chip-erase byte at wrong address
        unlock(4'h0);
        wr(19'h5555, 8'h80);
        unlock(4'h0);
        wr(19'h5556, 8'h10);
        exp_cmd("R8", 0); exp_mode("R8", 0);

        // R7 R10 R11: each sector erased, suspended, resumed
        for (int s = 0; s < 8; s++) begin
            unlock(4'(s));
            wr(19'h5555, 8'h80);
            unlock(4'(s + 1));
            wr({3'(s), 16'h0ABC}, 8'h30);
            exp_cmd("R7", 5);
            chk(cmd_addr[18:16] == 3'(s), "R7", "sector", int'(cmd_addr[18:16]), s);
            chk(cmd_addr == {3'(s), 16'h0ABC}, "R7", "addr", int'(cmd_addr), (s << 16) | 'h0ABC);
            exp_mode("R7", 2);
            wr(19'h12, 8'hB0);
            exp_cmd("R10", 6); exp_mode("R10", 0);
            wr(19'h0, 8'hF0);
            exp_cmd("R10", 0); exp_mode("R10", 0);
            wr(19'h33, 8'h30);
            exp_cmd("R11", 7); exp_mode("R11", 2);
            finish_op;
            exp_mode("R9", 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule